// File: doc/BRIEF.md
# Slope-Extrapolating Gamma Lookup

This block applies gamma correction to red, green and blue pixel components. Each of the 128 lookup entries carries, for every colour channel, a 10-bit base level and a compact floating-point slope made of a 2-bit exponent and a 4-bit mantissa. A channel's 10-bit input picks an entry with its upper seven bits. Its lower three bits give the position inside that interval. The output is the selected entry's base plus the slope scaled by that position. Only the selected entry is used and the next entry is never consulted, so the curve's top endpoint exists only as the last stored entry's base plus its slope.

Entries are loaded through a register-style write port in two 24-bit words. The low word holds the low eight base bits of each channel. The high word holds the slope fields and the two top base bits. The low word is staged, and the whole entry commits when the high word arrives. The pixel side accepts one three-channel sample per clock and returns the corrected sample exactly two cycles later with a matching valid flag.

Top module: `gamma_slope_lut`

## Requirements
- R1: While reset is held and in the cycles right after it, `out_valid` is 0 even if `pix_valid` was high during reset.
- R2: A low-word write (`wr_hi`=0) carries base bits 7:0 per channel: blue in data bits 7:0, green in 15:8, red in 23:16.
- R3: A high-word write (`wr_hi`=1) carries, per channel byte, the exponent in the byte's bits 7:6, the mantissa in bits 5:2 and base bits 9:8 in bits 1:0, with the same byte-to-channel assignment as R2.
- R4: A low-word write alone leaves the stored entry unchanged. A high-word write to address A commits entry A using the most recently written low word.
- R5: Per channel, input bits 9:3 select the entry and bits 2:0 form the fraction f. Pixel lanes are blue in bits 9:0, green in 19:10 and red in 29:20 of `pix_in` and `pix_out`.
- R6: The decoded slope is mantissa shifted left by exponent (0 to 120 output steps per interval).
- R7: The output is base + floor(slope*f/8), using only the selected entry, so a fraction of 0 returns the base unchanged.
- R8: When base plus increment exceeds 1023, the output is 1023.
- R9: A sample presented with `pix_valid` high appears on `pix_out` with `out_valid` high exactly two clock cycles later. Idle cycles give `out_valid` low, and back-to-back samples keep their order.
- R10: A sample presented in the same cycle as a committing high-word write to its entry uses the old entry. A sample presented in the following cycle uses the new one.
- R11: The three channels are looked up and computed independently and may select different entries in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Entry write strobe |
| wr_hi | input | 1 | 0 selects the low word, 1 the high (committing) word |
| wr_addr | input | 7 | Entry index for the write |
| wr_data | input | 24 | Write word |
| pix_valid | input | 1 | Input sample valid |
| pix_in | input | 30 | Input sample, three 10-bit lanes |
| out_valid | output | 1 | Output sample valid |
| pix_out | output | 30 | Corrected sample, three 10-bit lanes |

## Verification
The bench targets the top entry at full scale with the steepest slope, which must clip to 1023. A design without the clamp would wrap around to a small value. It places a flat entry next to a very different neighbour and samples at the largest fraction. An interpolating design would drift toward the neighbour, while this one must return the flat base. It also issues lone low-word writes, overlaps a committing write with a pixel on the same entry, and uses fractions whose product is not a multiple of eight. These catch entries torn by the low word, a read-after-write bypass, and rounding up instead of truncating.

// File: rtl/gamma_lut_pkg.sv
// Package: field widths and the entry record shared by the gamma lookup.
// Assumes an 8-bit low byte per channel and a 10-bit output level.
package gamma_lut_pkg;
    localparam int VAL_W    = 10;
    localparam int EXP_W    = 2;
    localparam int MANT_W   = 4;
    localparam int BYTE_W   = 8;
    localparam int HI_VAL_W = VAL_W - BYTE_W;
    localparam int ENT_W    = EXP_W + MANT_W + VAL_W;
    localparam int SLOPE_W  = MANT_W + (1 << EXP_W) - 1;

    typedef struct packed {
        logic [EXP_W-1:0]  ex;
        logic [MANT_W-1:0] man;
        logic [VAL_W-1:0]  base;
    } entry_t;
endpackage

// File: rtl/gamma_word_unpack.sv
// Module: splits a staged low word and a high word into per-channel entries.
// Assumes one byte per channel in each word, channel 0 in the lowest byte.
module gamma_word_unpack
    import gamma_lut_pkg::*;
#(
    parameter int CH_N = 3
) (
    input  logic [CH_N*BYTE_W-1:0] lo_word,
    input  logic [CH_N*BYTE_W-1:0] hi_word,
    output logic [CH_N*ENT_W-1:0]  ent_flat
);
    for (genvar c = 0; c < CH_N; c++) begin : g_ch
        logic [BYTE_W-1:0] hb;
        logic [BYTE_W-1:0] lb;
        entry_t            e;

        // Purpose: pick this channel's bytes and rebuild its entry fields.
        always_comb begin
            hb     = hi_word[c*BYTE_W +: BYTE_W];
            lb     = lo_word[c*BYTE_W +: BYTE_W];
            e.ex   = hb[BYTE_W-1 -: EXP_W];
            e.man  = hb[BYTE_W-EXP_W-1 -: MANT_W];
            e.base = {hb[HI_VAL_W-1:0], lb};
        end

        assign ent_flat[c*ENT_W +: ENT_W] = e;
    end
endmodule

// File: rtl/gamma_entry_store.sv
// Module: entry storage with a staged low word and one read port per channel.
// Assumes the low word is written before the high word. A read in the same cycle
// as a commit to the same entry returns the old contents.
module gamma_entry_store
    import gamma_lut_pkg::*;
#(
    parameter int IDX_W = 7,
    parameter int CH_N  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    wr_hi,
    input  logic [IDX_W-1:0]        wr_addr,
    input  logic [CH_N*BYTE_W-1:0]  wr_data,
    input  logic [CH_N*IDX_W-1:0]   rd_idx,
    output logic [CH_N*ENT_W-1:0]   rd_ent
);
    localparam int DEPTH = 1 << IDX_W;

    logic [CH_N*BYTE_W-1:0] stage_lo;
    logic [CH_N*ENT_W-1:0]  commit_ent;
    logic [CH_N*ENT_W-1:0]  mem [DEPTH];

    gamma_word_unpack #(.CH_N(CH_N)) u_unpack (
        .lo_word (stage_lo),
        .hi_word (wr_data),
        .ent_flat(commit_ent)
    );

    // Purpose: hold the latest low word until its high word arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stage_lo <= '0;
        else if (wr_en && !wr_hi)
            stage_lo <= wr_data;
    end

    // Purpose: commit a whole entry on the high-word write.
    always_ff @(posedge clk) begin
        if (wr_en && wr_hi)
            mem[wr_addr] <= commit_ent;
    end

    for (genvar c = 0; c < CH_N; c++) begin : g_rd
        // Purpose: registered lookup of this channel's slice of its own entry.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rd_ent[c*ENT_W +: ENT_W] <= '0;
            else
                rd_ent[c*ENT_W +: ENT_W] <= mem[rd_idx[c*IDX_W +: IDX_W]][c*ENT_W +: ENT_W];
        end
    end

    // R4: a commit stores the low bits staged before the high-word write
    a_r4_commit_staged_low: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_hi) |=> (mem[$past(wr_addr)][BYTE_W-1:0] == $past(stage_lo[BYTE_W-1:0])));
endmodule

// File: rtl/gamma_extrap.sv
// Module: one channel's slope decode, extrapolation and clamp, one register stage.
// Assumes the entry and fraction arrive registered together with in_valid.
module gamma_extrap
    import gamma_lut_pkg::*;
#(
    parameter int FRAC_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  entry_t            ent,
    input  logic [FRAC_W-1:0] frac,
    output logic [VAL_W-1:0]  result
);
    localparam int PROD_W = SLOPE_W + FRAC_W;
    localparam int SUM_W  = ((PROD_W > VAL_W) ? PROD_W : VAL_W) + 1;
    localparam logic [SUM_W-1:0] TOP = SUM_W'((1 << VAL_W) - 1);

    logic [SLOPE_W-1:0] slope;
    logic [PROD_W-1:0]  prod;
    logic [SUM_W-1:0]   sum;
    logic [VAL_W-1:0]   clamped;

    // Purpose: decode the slope, scale it by the fraction and clamp the sum.
    always_comb begin
        slope   = SLOPE_W'(ent.man) << ent.ex;
        prod    = PROD_W'(slope) * PROD_W'(frac);
        sum     = SUM_W'(ent.base) + SUM_W'(prod >> FRAC_W);
        clamped = (sum > TOP) ? TOP[VAL_W-1:0] : sum[VAL_W-1:0];
    end

    // Purpose: output register, loaded only for valid samples.
    always_ff @(posedge clk) begin
        if (!rst_n)
            result <= '0;
        else if (in_valid)
            result <= clamped;
    end

    // R7: never below the base of the selected entry
    a_r7_not_below_base: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (result >= $past(ent.base)));
    // R7: zero fraction returns the base exactly
    a_r7_zero_frac_base: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && frac == '0) |=> (result == $past(ent.base)));
endmodule

// File: rtl/gamma_slope_lut.sv
// Module: top of the three-channel slope-extrapolating gamma lookup.
// Stage 1 fetches each channel's entry, stage 2 extrapolates and clamps.
// Assumes VAL_W = IDX_W + fraction width and one byte per channel per word.
module gamma_slope_lut
    import gamma_lut_pkg::*;
#(
    parameter int IDX_W = 7,
    parameter int CH_N  = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   wr_hi,
    input  logic [IDX_W-1:0]       wr_addr,
    input  logic [CH_N*BYTE_W-1:0] wr_data,
    input  logic                   pix_valid,
    input  logic [CH_N*VAL_W-1:0]  pix_in,
    output logic                   out_valid,
    output logic [CH_N*VAL_W-1:0]  pix_out
);
    localparam int FRAC_W = VAL_W - IDX_W;

    logic [CH_N*IDX_W-1:0]  idx_flat;
    logic [CH_N*FRAC_W-1:0] frac_s1;
    logic [CH_N*ENT_W-1:0]  ent_s1;
    logic                   s1_valid;

    for (genvar c = 0; c < CH_N; c++) begin : g_idx
        assign idx_flat[c*IDX_W +: IDX_W] = pix_in[c*VAL_W + FRAC_W +: IDX_W];
    end

    gamma_entry_store #(.IDX_W(IDX_W), .CH_N(CH_N)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_hi  (wr_hi),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_idx (idx_flat),
        .rd_ent (ent_s1)
    );

    // Purpose: stage-1 valid and fractions travel alongside the fetched entries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            frac_s1  <= '0;
        end else begin
            s1_valid <= pix_valid;
            for (int c = 0; c < CH_N; c++)
                frac_s1[c*FRAC_W +: FRAC_W] <= pix_in[c*VAL_W +: FRAC_W];
        end
    end

    // Purpose: stage-2 valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_valid <= 1'b0;
        else
            out_valid <= s1_valid;
    end

    for (genvar c = 0; c < CH_N; c++) begin : g_ch
        gamma_extrap #(.FRAC_W(FRAC_W)) u_extrap (
            .clk     (clk),
            .rst_n   (rst_n),
            .in_valid(s1_valid),
            .ent     (entry_t'(ent_s1[c*ENT_W +: ENT_W])),
            .frac    (frac_s1[c*FRAC_W +: FRAC_W]),
            .result  (pix_out[c*VAL_W +: VAL_W])
        );
    end

    // R9: stage-1 valid only follows an accepted sample
    a_r9_stage1_from_input: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |-> $past(pix_valid));
    // R9: output valid only follows a stage-1 sample
    a_r9_out_from_stage1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(s1_valid));
    // R9: an accepted sample always reaches stage 1
    a_r9_input_reaches_stage1: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> s1_valid);
endmodule

// File: tb/gamma_slope_lut_bench.sv
module gamma_slope_lut_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_hi = 1'b0;
    logic [6:0]  wr_addr = '0;
    logic [23:0] wr_data = '0;
    logic        pix_valid = 1'b0;
    logic [29:0] pix_in = '0;
    logic        out_valid;
    logic [29:0] pix_out;

    always #4 clk = ~clk;

    gamma_slope_lut u_gamma_slope_lut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hi(wr_hi),
        .wr_addr(wr_addr), .wr_data(wr_data), .pix_valid(pix_valid),
        .pix_in(pix_in), .out_valid(out_valid), .pix_out(pix_out)
    );

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    // behavioural model state
    int m_base [3][128];
    int m_ex   [3][128];
    int m_man  [3][128];
    int m_lo = 0;

    // two-deep expectation pipe
    bit          e_valid [2];
    logic [29:0] e_data  [2];
    string       e_tag   [2];

    function automatic int model_lane(int c, int v);
        int idx, f, s, o;
        idx = v / 8;
        f   = v % 8;
        s   = m_man[c][idx] * (1 << m_ex[c][idx]);
        o   = m_base[c][idx] + (s * f) / 8;
        return (o > 1023) ? 1023 : o;
    endfunction

    task automatic check_out();
        compared++;
        if (out_valid !== e_valid[1]) begin
            mismatched++;
            $display("FAIL %s: out_valid=%0b expected %0b", e_tag[1], out_valid, e_valid[1]);
        end else if (e_valid[1] && pix_out !== e_data[1]) begin
            mismatched++;
            $display("FAIL %s: pix_out=%h expected %h", e_tag[1], pix_out, e_data[1]);
        end
    endtask

    // one clock: check, predict this cycle's sample, update model, drive inputs
    task automatic cyc(input bit we, input bit hi, input int addr, input logic [23:0] data,
                       input bit pv, input logic [29:0] pin, input string tag);
        logic [29:0] ex;
        @(negedge clk);
        check_out();
        for (int c = 0; c < 3; c++)
            ex[c*10 +: 10] = 10'(model_lane(c, int'(pin[c*10 +: 10])));
        e_valid[1] = e_valid[0]; e_data[1] = e_data[0]; e_tag[1] = e_tag[0];
        e_valid[0] = pv;         e_data[0] = ex;        e_tag[0] = tag;
        if (we && !hi) m_lo = int'(data);
        if (we && hi) begin
            for (int c = 0; c < 3; c++) begin
                m_ex[c][addr]   = int'(data[c*8+6 +: 2]);
                m_man[c][addr]  = int'(data[c*8+2 +: 4]);
                m_base[c][addr] = int'(data[c*8 +: 2]) * 256 + ((m_lo >> (c*8)) & 255);
            end
        end
        wr_en = we; wr_hi = hi; wr_addr = 7'(addr); wr_data = data;
        pix_valid = pv; pix_in = pin;
    endtask

    task automatic load(input int addr, input int b2, input int x2, input int n2,
                        input int b1, input int x1, input int n1,
                        input int b0, input int x0, input int n0);
        logic [23:0] lo, hi;
        lo = {8'(b2), 8'(b1), 8'(b0)};
        hi = {2'(x2), 4'(n2), 2'(b2 >> 8), 2'(x1), 4'(n1), 2'(b1 >> 8), 2'(x0), 4'(n0), 2'(b0 >> 8)};
        cyc(1, 0, addr, lo, 0, '0, "R2");
        cyc(1, 1, addr, hi, 0, '0, "R3");
    endtask

    function automatic logic [29:0] px(int r, int g, int b);
        return {10'(r), 10'(g), 10'(b)};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 2; i++) begin e_valid[i] = 0; e_data[i] = '0; e_tag[i] = "R1"; end
        // R1: samples offered during reset must not emerge
        pix_valid = 1'b1; pix_in = px(5, 6, 7);
        repeat (4) @(posedge clk);
        @(negedge clk);
        compared++;
        if (out_valid !== 1'b0) begin
            mismatched++;
            $display("FAIL R1: out_valid=%0b during reset expected 0", out_valid);
        end
        rst_n = 1'b1; pix_valid = 1'b0;

        // R2 R3: load every entry with distinct per-channel contents
        for (int i = 0; i < 128; i++)
            load(i, (i*8) % 1024, i % 4, i % 16,
                    1023 - i*8, (i/4) % 4, (i*3) % 16,
                    (i*13) % 1024, 3 - (i % 4), 15 - (i % 16));

        // R5 R6 R7 R11: sweep, channels on different entries
        for (int k = 0; k < 1024; k++)
            cyc(0, 0, 0, '0, 1, px(k, (k*37 + 11) % 1024, 1023 - k), "R5 R6 R11");

        // R7: flat entry beside a very different neighbour, top fraction
        load(20, 100, 0, 0, 100, 0, 0, 100, 0, 0);
        load(21, 900, 3, 15, 900, 3, 15, 900, 3, 15);
        cyc(0, 0, 0, '0, 1, px(167, 167, 167), "R7");
        // R7: truncation, slope 20 with fraction 5 gives +12
        load(30, 200, 2, 5, 200, 2, 5, 200, 2, 5);
        cyc(0, 0, 0, '0, 1, px(245, 245, 240), "R7");

        // R8: top entry with steepest slope clamps
        load(127, 1020, 3, 15, 1000, 3, 15, 1020, 0, 1);
        cyc(0, 0, 0, '0, 1, px(1023, 1023, 1023), "R8");
        cyc(0, 0, 0, '0, 1, px(1016, 1020, 1023), "R8");

        // R4: lone low words leave entry 40 as it was
        cyc(1, 0, 40, 24'hFFFFFF, 0, '0, "R4");
        cyc(0, 0, 0, '0, 1, px(327, 322, 320), "R4");
        cyc(1, 0, 40, 24'h123456, 0, '0, "R4");
        cyc(0, 0, 0, '0, 1, px(320, 323, 325), "R4");
        // R4: high word commits with the latest low word
        cyc(1, 1, 40, 24'h5A_96_C3, 0, '0, "R4");
        cyc(0, 0, 0, '0, 1, px(324, 327, 320), "R4");

        // R10: overlapping commit sees old entry, next cycle sees new
        cyc(1, 0, 50, 24'h010203, 0, '0, "R10");
        cyc(1, 1, 50, 24'hFF_00_7E, 1, px(406, 406, 406), "R10");
        cyc(0, 0, 0, '0, 1, px(406, 406, 406), "R10");

        // R9: bubbles and back-to-back samples
        for (int k = 0; k < 40; k++)
            cyc(0, 0, 0, '0, (k % 3) != 1, px(k*25, 1000 - k*7, k*11 + 3), "R9");

        // drain
        for (int k = 0; k < 3; k++)
            cyc(0, 0, 0, '0, 0, '0, "R9");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule